// File: doc/BRIEF.md
# Virtually indexed, physically tagged direct-mapped data cache

This block is a small direct-mapped data cache that sits beside a TLB in a load/store pipeline stage. The set index and the word select come only from the untranslated page-offset bits of the virtual address. The tag/valid/dirty array and the data array are therefore read in the same cycle as the TLB lookup. The physical page number delivered by the TLB is compared against the stored physical tag only once both results are present. Only the page-offset bits of the address enter the cache. The virtual page number goes to the TLB alone.

A request stays asserted until `cpu_ready` rises. On a hit with a valid translation the access completes in the cycle it is presented: a read returns its word and a write updates the word and marks the line dirty. On a miss the cache stalls. It first writes a dirty victim back to memory one word per accepted beat, then fills the new line from memory one word per beat, and then completes the access from the filled line. The memory port is word-serial and each beat is accepted by `mem_ack`.

The controller has three states:
- `ST_LOOKUP` is the idle/compare state.
- `ST_EVICT` writes back a dirty victim.
- `ST_FILL` loads the new line.

The transitions are:
- LOOKUP→EVICT on a translated miss whose victim is valid and dirty.
- LOOKUP→FILL on a translated miss whose victim is clean or invalid.
- EVICT→FILL on the acknowledged last write-back beat.
- FILL→LOOKUP on the acknowledged last fill beat.

Every other cycle holds the state.

Top module: `vipt_cache`

## Requirements
- R1: After reset every line is invalid, `mem_req` and `cpu_ready` are low, and the first access to any address misses.
- R2: Address field positions are fixed. Byte offset is bits 1:0, word select is bits 3:2 and line index is bits 6:4. A translated read that hits raises `cpu_ready` in the same cycle the request is presented and returns the addressed word on `cpu_rdata`.
- R3: A line hits only if it is valid and its stored physical tag equals the concatenation of `tlb_ppn` with virtual address bits 11:7. The stored tag is 25 bits wide. Any difference in either part is a miss.
- R4: While `tlb_hit` is low, a request leaves `cpu_ready` and `mem_req` low and changes no cache state. A write made under a TLB miss is not stored.
- R5: A write that hits stores `cpu_wdata` into the addressed word and marks the line dirty. A later read of that word returns the new value.
- R6: A miss on a clean or invalid line issues four read beats (`mem_we` low). The beats go to physical word addresses {tag, index, beat, 2'b00} for beat 0 to 3 in ascending order. The access then completes from the filled line, and the filled line is clean.
- R7: A miss on a valid dirty line first issues four write beats (`mem_we` high). These go to {stored tag, index, beat, 2'b00}, beat 0 to 3, carrying the line's words. The fill follows them.
- R8: While a miss is being handled, `cpu_ready` stays low and `mem_req` stays high. The beat and the state advance only on `mem_ack`.
- R9: A line that was filled and not written causes no write-back when it is later replaced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_vwoff | input | 10 | Virtual address bits 11:2 (word-aligned page offset) |
| cpu_wdata | input | 32 | Write data |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ready` on a read |
| tlb_hit | input | 1 | TLB translation present for the current request |
| tlb_ppn | input | 20 | Translated physical page number |
| mem_req | output | 1 | Memory beat requested |
| mem_we | output | 1 | 1 = write-back beat, 0 = fill beat |
| mem_addr | output | 32 | Physical word address of the beat |
| mem_wdata | output | 32 | Write-back data |
| mem_ack | input | 1 | Memory accepts the current beat |
| mem_rdata | input | 32 | Fill data, valid with `mem_ack` |

## Verification
A wrong valid, tag or dirty bit shows up at the ports on the next access to that index. It appears as a `cpu_ready` that arrives a cycle early or late, a missing or extra write-back burst, or beats aimed at the wrong physical address. A corrupted data word appears only when that word is read back, or when its line is evicted and the write-back beat carries it. The bench therefore pairs every access with a behavioural model of lines and backing memory, and checks ready timing, every memory beat and every returned word as each access ends.

// File: rtl/vipt_pkg.sv
package vipt_pkg;

    typedef enum logic [1:0] {
        ST_LOOKUP = 2'd0,
        ST_EVICT  = 2'd1,
        ST_FILL   = 2'd2
    } vipt_state_e;

endpackage

// File: rtl/vipt_tag_store.sv
module vipt_tag_store #(
    parameter int LINES  = 8,
    parameter int TAG_W  = 25,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    output logic             rd_valid,
    output logic             rd_dirty,
    output logic [TAG_W-1:0] rd_tag,
    input  logic             install,
    input  logic [TAG_W-1:0] install_tag,
    input  logic             set_dirty
);

    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] dirty_q;
    logic [TAG_W-1:0] tag_q [LINES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else begin
            if (install) begin
                valid_q[idx] <= 1'b1;
                dirty_q[idx] <= 1'b0;
            end else if (set_dirty) begin
                dirty_q[idx] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (install) begin
            tag_q[idx] <= install_tag;
        end
    end

    assign rd_valid = valid_q[idx];
    assign rd_dirty = dirty_q[idx];
    assign rd_tag   = tag_q[idx];

    AST_DIRTY_AFTER_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        set_dirty |=> dirty_q[$past(idx)]); // R5
    AST_FILLED_LINE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        install |=> (valid_q[$past(idx)] && !dirty_q[$past(idx)])); // R9

endmodule

// File: rtl/vipt_data_store.sv
module vipt_data_store #(
    parameter int LINES   = 8,
    parameter int WORDS   = 4,
    parameter int DATA_W  = 32,
    localparam int IDX_W  = $clog2(LINES),
    localparam int WSEL_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WSEL_W-1:0] rd_word,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [WSEL_W-1:0] wr_word,
    input  logic [DATA_W-1:0] wr_data
);

    logic [DATA_W-1:0] mem_q [LINES][WORDS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[idx][wr_word] <= wr_data;
        end
    end

    assign rd_data = mem_q[idx][rd_word];

endmodule

// File: rtl/vipt_ctrl.sv
module vipt_ctrl
    import vipt_pkg::*;
#(
    parameter int WORDS   = 4,
    localparam int WSEL_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic              tlb_hit,
    input  logic              line_hit,
    input  logic              victim_dirty,
    input  logic              mem_ack,
    output logic [WSEL_W-1:0] beat,
    output logic              cpu_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic              fill_we,
    output logic              install,
    output logic              store_we
);

    localparam logic [WSEL_W-1:0] LAST_BEAT = WSEL_W'(WORDS - 1);

    vipt_state_e       state_q, state_d;
    logic [WSEL_W-1:0] beat_q,  beat_d;
    logic              translated;
    logic              beat_last;

    assign translated = req && tlb_hit;
    assign beat_last  = (beat_q == LAST_BEAT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_LOOKUP;
            beat_q  <= '0;
        end else begin
            state_q <= state_d;
            beat_q  <= beat_d;
        end
    end

    always_comb begin
        state_d = state_q;
        beat_d  = beat_q;
        unique case (state_q)
            ST_LOOKUP: begin
                beat_d = '0;
                if (translated && !line_hit) begin
                    state_d = victim_dirty ? ST_EVICT : ST_FILL;
                end
            end
            ST_EVICT: begin
                if (mem_ack) begin
                    beat_d = beat_last ? '0 : beat_q + 1'b1;
                    if (beat_last) begin
                        state_d = ST_FILL;
                    end
                end
            end
            ST_FILL: begin
                if (mem_ack) begin
                    beat_d = beat_last ? '0 : beat_q + 1'b1;
                    if (beat_last) begin
                        state_d = ST_LOOKUP;
                    end
                end
            end
            default: begin
                state_d = ST_LOOKUP;
                beat_d  = '0;
            end
        endcase
    end

    always_comb begin
        cpu_ready = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        fill_we   = 1'b0;
        install   = 1'b0;
        store_we  = 1'b0;
        unique case (state_q)
            ST_LOOKUP: begin
                cpu_ready = translated && line_hit;
                store_we  = translated && line_hit && we;
            end
            ST_EVICT: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            ST_FILL: begin
                mem_req = 1'b1;
                fill_we = mem_ack;
                install = mem_ack && beat_last;
            end
            default: begin
                cpu_ready = 1'b0;
            end
        endcase
    end

    assign beat = beat_q;

    AST_READY_NEEDS_TLB: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> tlb_hit); // R4
    AST_TLB_MISS_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOKUP && req && !tlb_hit) |=> (state_q == ST_LOOKUP)); // R4
    AST_CLEAN_MISS_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOKUP && translated && !line_hit && !victim_dirty)
        |=> (state_q == ST_FILL && beat_q == '0)); // R6
    AST_DIRTY_MISS_EVICTS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOKUP && translated && !line_hit && victim_dirty)
        |=> (state_q == ST_EVICT && beat_q == '0)); // R7
    AST_EVICT_THEN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EVICT && mem_ack && beat_last) |=> (state_q == ST_FILL)); // R7
    AST_BEAT_WAITS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> ($stable(beat_q) && $stable(state_q) && mem_req)); // R8
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !cpu_ready); // R8

endmodule

// File: rtl/vipt_cache.sv
module vipt_cache #(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int PAGE_BITS = 12,
    parameter int LINES     = 8,
    parameter int WORDS     = 4,
    localparam int BYTE_W   = $clog2(DATA_W / 8),
    localparam int WSEL_W   = $clog2(WORDS),
    localparam int IDX_W    = $clog2(LINES),
    localparam int OFF_W    = BYTE_W + WSEL_W,
    localparam int PPN_W    = ADDR_W - PAGE_BITS,
    localparam int XTRA_W   = PAGE_BITS - IDX_W - OFF_W,
    localparam int TAG_W    = ADDR_W - IDX_W - OFF_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cpu_req,
    input  logic                        cpu_we,
    input  logic [PAGE_BITS-1:BYTE_W]   cpu_vwoff,
    input  logic [DATA_W-1:0]           cpu_wdata,
    output logic                        cpu_ready,
    output logic [DATA_W-1:0]           cpu_rdata,
    input  logic                        tlb_hit,
    input  logic [PPN_W-1:0]            tlb_ppn,
    output logic                        mem_req,
    output logic                        mem_we,
    output logic [ADDR_W-1:0]           mem_addr,
    output logic [DATA_W-1:0]           mem_wdata,
    input  logic                        mem_ack,
    input  logic [DATA_W-1:0]           mem_rdata
);

    logic [IDX_W-1:0]  line_idx;
    logic [WSEL_W-1:0] cpu_word;
    logic [TAG_W-1:0]  phys_tag;
    logic              rd_valid, rd_dirty;
    logic [TAG_W-1:0]  rd_tag;
    logic              line_hit, victim_dirty;
    logic [WSEL_W-1:0] beat;
    logic              fill_we, install, store_we;
    logic              arr_we;
    logic [WSEL_W-1:0] arr_rd_word, arr_wr_word;
    logic [DATA_W-1:0] arr_wr_data, arr_rd_data;

    assign line_idx = cpu_vwoff[OFF_W+IDX_W-1:OFF_W];
    assign cpu_word = cpu_vwoff[OFF_W-1:BYTE_W];

    generate
        if (XTRA_W > 0) begin : g_tag_ext
            assign phys_tag = {tlb_ppn, cpu_vwoff[PAGE_BITS-1:PAGE_BITS-XTRA_W]};
        end else begin : g_tag_ppn
            assign phys_tag = tlb_ppn;
        end
    endgenerate

    assign line_hit     = rd_valid && (rd_tag == phys_tag);
    assign victim_dirty = rd_valid && rd_dirty;

    vipt_tag_store #(
        .LINES (LINES),
        .TAG_W (TAG_W)
    ) u_tags (
        .clk         (clk),
        .rst_n       (rst_n),
        .idx         (line_idx),
        .rd_valid    (rd_valid),
        .rd_dirty    (rd_dirty),
        .rd_tag      (rd_tag),
        .install     (install),
        .install_tag (phys_tag),
        .set_dirty   (store_we)
    );

    assign arr_we      = fill_we || store_we;
    assign arr_wr_word = fill_we ? beat : cpu_word;
    assign arr_wr_data = fill_we ? mem_rdata : cpu_wdata;
    assign arr_rd_word = mem_we ? beat : cpu_word;

    vipt_data_store #(
        .LINES  (LINES),
        .WORDS  (WORDS),
        .DATA_W (DATA_W)
    ) u_data (
        .clk     (clk),
        .idx     (line_idx),
        .rd_word (arr_rd_word),
        .rd_data (arr_rd_data),
        .wr_en   (arr_we),
        .wr_word (arr_wr_word),
        .wr_data (arr_wr_data)
    );

    vipt_ctrl #(
        .WORDS (WORDS)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req          (cpu_req),
        .we           (cpu_we),
        .tlb_hit      (tlb_hit),
        .line_hit     (line_hit),
        .victim_dirty (victim_dirty),
        .mem_ack      (mem_ack),
        .beat         (beat),
        .cpu_ready    (cpu_ready),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .fill_we      (fill_we),
        .install      (install),
        .store_we     (store_we)
    );

    assign cpu_rdata = arr_rd_data;
    assign mem_wdata = arr_rd_data;
    assign mem_addr  = {(mem_we ? rd_tag : phys_tag), line_idx, beat, {BYTE_W{1'b0}}};

    AST_ADDR_HELD_IN_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> $stable(mem_addr)); // R8
    AST_WB_FROM_DIRTY_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (rd_valid && rd_dirty)); // R7

endmodule

// File: tb/vipt_cache_tb.sv
module vipt_cache_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [11:2] cpu_vwoff = '0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_ready;
    logic [31:0] cpu_rdata;
    logic        tlb_hit = 1'b0;
    logic [19:0] tlb_ppn = '0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #4 clk = ~clk;

    vipt_cache u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_req   (cpu_req),
        .cpu_we    (cpu_we),
        .cpu_vwoff (cpu_vwoff),
        .cpu_wdata (cpu_wdata),
        .cpu_ready (cpu_ready),
        .cpu_rdata (cpu_rdata),
        .tlb_hit   (tlb_hit),
        .tlb_ppn   (tlb_ppn),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct packed {
        logic        we;
        logic [31:0] addr;
        logic [31:0] data;
    } beat_t;

    logic [31:0] bmem [int unsigned];
    beat_t       seen_q [$];

    // reference model of the cache contents
    bit          m_valid [8];
    bit          m_dirty [8];
    logic [24:0] m_tag   [8];
    logic [31:0] m_data  [8][4];

    function automatic logic [31:0] mem_rd(logic [31:0] a);
        if (bmem.exists(int'(a))) return bmem[int'(a)];
        return a ^ 32'hC3A5_0000 ^ {a[15:0], 16'h0};
    endfunction

    task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    // memory responder: accepts every other requested beat
    initial begin : responder
        int tog;
        tog = 0;
        forever begin
            @(negedge clk);
            mem_ack = 1'b0;
            if (mem_req === 1'b1) begin
                tog++;
                if (tog % 2 == 0) begin
                    mem_ack = 1'b1;
                    if (mem_we) begin
                        bmem[int'(mem_addr)] = mem_wdata;
                        seen_q.push_back('{1'b1, mem_addr, mem_wdata});
                    end else begin
                        mem_rdata = mem_rd(mem_addr);
                        seen_q.push_back('{1'b0, mem_addr, mem_rdata});
                    end
                end
            end
        end
    end

    task automatic access(bit we, logic [11:0] va, logic [19:0] ppn,
                          logic [31:0] wd, string rq);
        logic [2:0]  idx;
        logic [1:0]  w;
        logic [24:0] ptag;
        bit          hit;
        int          n;
        beat_t       exp_q [$];
        idx  = va[6:4];
        w    = va[3:2];
        ptag = {ppn, va[11:7]};
        hit  = m_valid[idx] && (m_tag[idx] == ptag);
        if (!hit) begin
            if (m_valid[idx] && m_dirty[idx]) begin
                for (int b = 0; b < 4; b++)
                    exp_q.push_back('{1'b1, {m_tag[idx], idx, 2'(b), 2'b00}, m_data[idx][b]});
            end
            for (int b = 0; b < 4; b++)
                exp_q.push_back('{1'b0, {ptag, idx, 2'(b), 2'b00}, 32'h0});
        end
        seen_q.delete();
        @(negedge clk);
        cpu_req   = 1'b1;
        cpu_we    = we;
        cpu_vwoff = va[11:2];
        cpu_wdata = wd;
        tlb_hit   = 1'b1;
        tlb_ppn   = ppn;
        #1;
        chk(rq, "R2 ready in presenting cycle equals hit", 32'(cpu_ready), 32'(hit));
        n = 0;
        while (cpu_ready !== 1'b1 && n < 200) begin
            @(negedge clk);
            #1;
            n++;
            if (cpu_ready !== 1'b1)
                chk(rq, "R8 mem_req held while stalled", 32'(mem_req), 32'd1);
        end
        chk(rq, "access completes", 32'(cpu_ready), 32'd1);
        chk(rq, "R6/R7 beat count", 32'(seen_q.size()), 32'(exp_q.size()));
        for (int i = 0; i < exp_q.size() && i < seen_q.size(); i++) begin
            chk(rq, "R6/R7 beat direction", 32'(seen_q[i].we), 32'(exp_q[i].we));
            chk(rq, "R6/R7 beat address", seen_q[i].addr, exp_q[i].addr);
            if (exp_q[i].we)
                chk(rq, "R7 write-back data", seen_q[i].data, exp_q[i].data);
        end
        if (!hit) begin
            for (int b = 0; b < 4; b++)
                m_data[idx][b] = mem_rd({ptag, idx, 2'(b), 2'b00});
            m_valid[idx] = 1'b1;
            m_dirty[idx] = 1'b0;
            m_tag[idx]   = ptag;
        end
        if (we) begin
            m_data[idx][w] = wd;
            m_dirty[idx]   = 1'b1;
        end else begin
            chk(rq, "read data", cpu_rdata, m_data[idx][w]);
        end
        @(negedge clk);
        cpu_req = 1'b0;
        cpu_we  = 1'b0;
    endtask

    task automatic tlb_miss(bit we, logic [11:0] va, logic [19:0] ppn, logic [31:0] wd);
        @(negedge clk);
        cpu_req   = 1'b1;
        cpu_we    = we;
        cpu_vwoff = va[11:2];
        cpu_wdata = wd;
        tlb_hit   = 1'b0;
        tlb_ppn   = ppn;
        for (int i = 0; i < 4; i++) begin
            #1;
            chk("R4", "ready under TLB miss", 32'(cpu_ready), 32'd0);
            chk("R4", "mem_req under TLB miss", 32'(mem_req), 32'd0);
            @(negedge clk);
        end
        cpu_req = 1'b0;
        tlb_hit = 1'b1;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog run did not end actual=hung expected=done");
            finish_run();
        end
    end

    initial begin : main
        logic [31:0] lcg;
        for (int i = 0; i < 8; i++) begin
            m_valid[i] = 1'b0;
            m_dirty[i] = 1'b0;
            m_tag[i]   = '0;
        end
        repeat (3) @(negedge clk);
        #1;
        chk("R1", "mem_req in reset", 32'(mem_req), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1", "mem_req after reset", 32'(mem_req), 32'd0);
        chk("R1", "ready after reset", 32'(cpu_ready), 32'd0);

        // cold miss, clean fill
        access(1'b0, 12'h234, 20'h305BC, 32'h0, "R1 R6 cold read");
        // same-cycle hits
        access(1'b0, 12'h234, 20'h305BC, 32'h0, "R2 read hit");
        access(1'b0, 12'h238, 20'h305BC, 32'h0, "R2 other word hit");
        // write hit then read back
        access(1'b1, 12'h23C, 20'h305BC, 32'hDEAD_BEEF, "R5 write hit");
        access(1'b0, 12'h23C, 20'h305BC, 32'h0, "R5 read back");
        // TLB miss must not store
        tlb_miss(1'b1, 12'h23C, 20'h305BC, 32'h1234_5678);
        access(1'b0, 12'h23C, 20'h305BC, 32'h0, "R4 value unchanged");
        // different PPN, same index: dirty victim written back
        access(1'b0, 12'h234, 20'h1A2B3, 32'h0, "R3 R7 conflict dirty");
        // same PPN, different bits 11:7: clean victim, no write-back
        access(1'b0, 12'hFB4, 20'h1A2B3, 32'h0, "R3 R9 conflict clean");
        // original data returns from memory after its write-back
        access(1'b0, 12'h23C, 20'h305BC, 32'h0, "R7 refetch written word");

        lcg = 32'h1357_9BDF;
        for (int i = 0; i < 300; i++) begin
            logic [11:0] va;
            logic [19:0] ppn;
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            va  = {4'b0, lcg[20], lcg[18:16], lcg[13:12], 2'b00};
            ppn = lcg[24] ? 20'h305BC : 20'h1A2B3;
            access(lcg[27], va, ppn, lcg ^ 32'hA5A5_0F0F, "R2 R5 R6 R7 R9 mixed");
        end

        done = 1;
        finish_run();
    end

endmodule